// File: doc/BRIEF.md
# Radar Front-End Configuration Controller

This block turns host register writes into the control traffic of a reconfigurable radar transceiver. It keeps a table of waveform presets, each preset being a fixed number of synthesizer setting words. When the host commands a preset, the controller shifts every word of that preset, one after another, out over a serial link to the waveform generator, with a load strobe after each word. It also turns the two receive-gain codes into serial frames for a dual-channel gain DAC, and it drives the line that picks one of two transmit antennas.

A host writes the preset table, the gain pair and the antenna choice through a plain single-cycle register bus. Reads return the table, the applied settings and two busy flags. Serial traffic never blocks the host. A write that lands while the matching serial link is busy is held, one entry per register, and carried out once the link goes idle. The antenna output changes only on a rising edge of the ramp trigger, so the antenna never switches in the middle of a ramp.

Register map (word addresses): 0 = preset command (bit 0 starts a send, bits [PSEL_W:1] pick the preset), 1 = gains (bits [7:0] channel A, bits [15:8] channel B), 2 = antenna (bit 0 request; bit 1 reads the applied line), 3 = status (read only), 64 + preset*WORDS + word = table entry.

Top module: `rfcfg_ctrl`

## Requirements
- R1: After reset both serial clocks and the load strobe are low, the DAC chip select is high, the antenna line is 0, status reads 0 and the gain register reads 0.
- R2: Writing address 0 with bit 0 = 1 sends all WORDS words of the preset named by bits [PSEL_W:1], lowest word index first. Each word goes out MSB first as WORD_W bits and is followed by one load strobe pulse. Writing address 0 with bit 0 = 0 sends nothing.
- R3: Table entry `preset*WORDS + word` is written and read at address 64 + that index.
- R4: Status bit 0 is 1 from the cycle after a preset command until the last strobe of all queued sends has ended. It is 1 whenever the strobe is high.
- R5: A gain frame is 16 bits sent MSB first while chip select is low. Bit 15 is the channel (0 = A, 1 = B), bits 14:8 are zero and bits 7:0 are the code. Address 1 reads back the applied pair as {B, A}.
- R6: A gain write sends one frame for each channel whose code differs from the applied one. If both differ, the A frame goes first and the B frame follows it back to back. If neither differs, no frame is sent.
- R7: The antenna line takes address 2 bit 0 only on a rising edge of the ramp trigger, and holds its value otherwise.
- R8: Table writes and preset commands that arrive while the synthesizer link is busy are held and carried out after it ends. A held table write is committed before a held preset send starts, and a held table write is not visible on readback until then.
- R9: Gain writes that arrive while the DAC link is busy are held, with the last one kept, and applied after the link ends. Status bit 1 is 1 while a frame is in flight or held.
- R10: Each serial bit holds its clock low for DIV cycles and then high for DIV cycles. The data line is stable while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | ADDR_W | Register word address (write and read) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for host_addr |
| ramp_trig | input | 1 | Ramp trigger, synchronous to clk |
| synth_sclk | output | 1 | Synthesizer serial clock |
| synth_sdo | output | 1 | Synthesizer serial data |
| synth_le | output | 1 | Synthesizer word load strobe |
| dac_sclk | output | 1 | Gain DAC serial clock |
| dac_sdo | output | 1 | Gain DAC serial data |
| dac_cs_n | output | 1 | Gain DAC chip select, active low |
| ant_sel | output | 1 | Transmit antenna select |

## Verification
The bench builds the block with its default parameters: four presets of four 32-bit words and a divider of 2. At that size every table entry can be written and read back, every preset can be sent and checked word by word, and a queued send can be chained behind a running one, all in a few thousand cycles. The gain sweep covers A-only, B-only, both-changed and unchanged writes against an arithmetic model of the applied pair. A burst of three writes while the DAC is busy shows that the last held value wins.

// File: rtl/rfc_pkg.sv
`timescale 1ns/1ps
package rfc_pkg;
    localparam int HDATA_W  = 32;
    localparam int ADR_WAVE = 0;
    localparam int ADR_GAIN = 1;
    localparam int ADR_ANT  = 2;
    localparam int ADR_STAT = 3;
    localparam int ADR_LUT  = 64;

    typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} sh_state_t;
    typedef enum logic [1:0] {WV_IDLE, WV_FETCH, WV_SHIFT, WV_STROBE} wv_state_t;
    typedef enum logic [1:0] {GN_IDLE, GN_LAUNCH, GN_WAIT} gn_state_t;
endpackage

// File: rtl/rfc_shifter.sv
`timescale 1ns/1ps
module rfc_shifter
    import rfc_pkg::*;
#(
    parameter int W   = 16,
    parameter int DIV = 2,
    localparam int CNT_W = $clog2(W),
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] din,
    output logic         sclk,
    output logic         sdo,
    output logic         active,
    output logic         done
);
    sh_state_t        state;
    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] bitcnt;
    logic [DIV_W-1:0] divcnt;
    logic             div_end;

    assign div_end = (divcnt == DIV_W'(DIV - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= SH_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
            divcnt <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                SH_IDLE: begin
                    if (start) begin
                        shreg  <= din;
                        bitcnt <= CNT_W'(W - 1);
                        divcnt <= '0;
                        state  <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (div_end) begin
                        divcnt <= '0;
                        state  <= SH_HIGH;
                    end else begin
                        divcnt <= divcnt + 1'b1;
                    end
                end
                SH_HIGH: begin
                    if (div_end) begin
                        divcnt <= '0;
                        if (bitcnt == '0) begin
                            state <= SH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            shreg  <= shreg << 1;
                            bitcnt <= bitcnt - 1'b1;
                            state  <= SH_LOW;
                        end
                    end else begin
                        divcnt <= divcnt + 1'b1;
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sclk   = 1'b0;
        active = 1'b1;
        sdo    = shreg[W-1];
        unique case (state)
            SH_IDLE: begin
                active = 1'b0;
                sdo    = 1'b0;
            end
            SH_LOW:  sclk = 1'b0;
            SH_HIGH: sclk = 1'b1;
            default: active = 1'b0;
        endcase
    end
endmodule

// File: rtl/rfc_wave_seq.sv
`timescale 1ns/1ps
module rfc_wave_seq
    import rfc_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int WORDS       = 4,
    parameter int NUM_PRESETS = 4,
    parameter int DIV         = 2,
    localparam int PSEL_W = (NUM_PRESETS > 1) ? $clog2(NUM_PRESETS) : 1,
    localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int LIDX_W = $clog2(NUM_PRESETS * WORDS),
    localparam int SC_W   = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [PSEL_W-1:0] go_idx,
    output logic [LIDX_W-1:0] lut_idx,
    input  logic [WORD_W-1:0] lut_word,
    output logic              busy,
    output logic              sclk,
    output logic              sdo,
    output logic              le
);
    wv_state_t         state;
    logic [PSEL_W-1:0] idx_q;
    logic [WIDX_W-1:0] wcnt;
    logic [SC_W-1:0]   scnt;
    logic              sh_start, sh_active, sh_done;

    assign lut_idx = LIDX_W'(idx_q) * LIDX_W'(WORDS) + LIDX_W'(wcnt);

    rfc_shifter #(.W(WORD_W), .DIV(DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .din(lut_word),
        .sclk(sclk), .sdo(sdo), .active(sh_active), .done(sh_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WV_IDLE;
            idx_q <= '0;
            wcnt  <= '0;
            scnt  <= '0;
        end else begin
            unique case (state)
                WV_IDLE: begin
                    if (go) begin
                        idx_q <= go_idx;
                        wcnt  <= '0;
                        state <= WV_FETCH;
                    end
                end
                WV_FETCH: state <= WV_SHIFT;
                WV_SHIFT: begin
                    if (sh_done) begin
                        scnt  <= '0;
                        state <= WV_STROBE;
                    end
                end
                WV_STROBE: begin
                    if (scnt == SC_W'(DIV - 1)) begin
                        if (wcnt == WIDX_W'(WORDS - 1)) begin
                            state <= WV_IDLE;
                        end else begin
                            wcnt  <= wcnt + 1'b1;
                            state <= WV_FETCH;
                        end
                    end else begin
                        scnt <= scnt + 1'b1;
                    end
                end
                default: state <= WV_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b1;
        le       = 1'b0;
        sh_start = 1'b0;
        unique case (state)
            WV_IDLE:   busy     = sh_active;
            WV_FETCH:  sh_start = 1'b1;
            WV_SHIFT:  le       = 1'b0;
            WV_STROBE: le       = 1'b1;
            default:   busy     = 1'b0;
        endcase
    end
endmodule

// File: rtl/rfc_gain_seq.sv
`timescale 1ns/1ps
module rfc_gain_seq
    import rfc_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int DIV    = 2,
    localparam int FRAME_W = 2 * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              chg_a,
    input  logic              chg_b,
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    output logic              busy,
    output logic              sclk,
    output logic              sdo,
    output logic              cs_n
);
    gn_state_t          state;
    logic               pa, pb;
    logic [CODE_W-1:0]  ca, cb;
    logic [FRAME_W-1:0] frame;
    logic               sh_start, sh_active, sh_done;

    assign frame = pa ? {1'b0, (CODE_W-1)'(0), ca} : {1'b1, (CODE_W-1)'(0), cb};

    rfc_shifter #(.W(FRAME_W), .DIV(DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .din(frame),
        .sclk(sclk), .sdo(sdo), .active(sh_active), .done(sh_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= GN_IDLE;
            pa    <= 1'b0;
            pb    <= 1'b0;
            ca    <= '0;
            cb    <= '0;
        end else begin
            unique case (state)
                GN_IDLE: begin
                    if (go) begin
                        pa    <= chg_a;
                        pb    <= chg_b;
                        ca    <= code_a;
                        cb    <= code_b;
                        state <= GN_LAUNCH;
                    end
                end
                GN_LAUNCH: begin
                    if (pa) pa <= 1'b0;
                    else    pb <= 1'b0;
                    state <= GN_WAIT;
                end
                GN_WAIT: begin
                    if (sh_done) state <= (pa || pb) ? GN_LAUNCH : GN_IDLE;
                end
                default: state <= GN_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b1;
        sh_start = 1'b0;
        cs_n     = !sh_active;
        unique case (state)
            GN_IDLE:   busy     = sh_active;
            GN_LAUNCH: sh_start = 1'b1;
            GN_WAIT:   busy     = 1'b1;
            default:   busy     = 1'b0;
        endcase
    end
endmodule

// File: rtl/rfcfg_ctrl.sv
`timescale 1ns/1ps
module rfcfg_ctrl
    import rfc_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int WORDS       = 4,
    parameter int NUM_PRESETS = 4,
    parameter int DIV         = 2,
    parameter int ADDR_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [HDATA_W-1:0] host_wdata,
    output logic [HDATA_W-1:0] host_rdata,
    input  logic               ramp_trig,
    output logic               synth_sclk,
    output logic               synth_sdo,
    output logic               synth_le,
    output logic               dac_sclk,
    output logic               dac_sdo,
    output logic               dac_cs_n,
    output logic               ant_sel
);
    localparam int LUT_N  = NUM_PRESETS * WORDS;
    localparam int LIDX_W = $clog2(LUT_N);
    localparam int PSEL_W = (NUM_PRESETS > 1) ? $clog2(NUM_PRESETS) : 1;
    localparam int CODE_W = 8;

    logic [WORD_W-1:0] lut [LUT_N];

    logic              wr_wave, wr_gain, wr_ant, wr_lut, lut_hit;
    logic [LIDX_W-1:0] lut_off, seq_lidx, lut_waddr;
    logic [PSEL_W-1:0] wr_idx, go_idx, pend_idx, cur_idx;
    logic              apply_pend, wave_go, wave_busy;
    logic              lut_pend, lut_we;
    logic [LIDX_W-1:0] lut_pend_idx;
    logic [WORD_W-1:0] lut_pend_data, lut_wdata;
    logic [CODE_W-1:0] gain_a, gain_b;
    logic              gain_pend, gain_go, dac_busy, chg_a, chg_b;
    logic [2*CODE_W-1:0] gain_pend_val, gain_val;
    logic              ant_req, ramp_q;

    // host decode
    assign lut_hit = (host_addr >= ADDR_W'(ADR_LUT)) && (host_addr < ADDR_W'(ADR_LUT + LUT_N));
    assign lut_off = LIDX_W'(host_addr - ADDR_W'(ADR_LUT));
    assign wr_wave = host_wr && (host_addr == ADDR_W'(ADR_WAVE)) && host_wdata[0];
    assign wr_gain = host_wr && (host_addr == ADDR_W'(ADR_GAIN));
    assign wr_ant  = host_wr && (host_addr == ADDR_W'(ADR_ANT));
    assign wr_lut  = host_wr && lut_hit;
    assign wr_idx  = host_wdata[PSEL_W:1];

    // waveform preset dispatch; a held command goes first when the link frees
    assign wave_go = !wave_busy && (apply_pend || wr_wave);
    assign go_idx  = apply_pend ? pend_idx : wr_idx;

    // table write port; a held write lands before any new one
    assign lut_we    = !wave_busy && (lut_pend || wr_lut);
    assign lut_waddr = lut_pend ? lut_pend_idx : lut_off;
    assign lut_wdata = lut_pend ? lut_pend_data : WORD_W'(host_wdata);

    always_ff @(posedge clk) begin
        if (lut_we) lut[lut_waddr] <= lut_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            apply_pend    <= 1'b0;
            pend_idx      <= '0;
            cur_idx       <= '0;
            lut_pend      <= 1'b0;
            lut_pend_idx  <= '0;
            lut_pend_data <= '0;
        end else begin
            if (wave_go) cur_idx <= go_idx;
            if (wr_wave && (wave_busy || apply_pend)) begin
                apply_pend <= 1'b1;
                pend_idx   <= wr_idx;
            end else if (!wave_busy && apply_pend) begin
                apply_pend <= 1'b0;
            end
            if (wr_lut && (wave_busy || lut_pend)) begin
                lut_pend      <= 1'b1;
                lut_pend_idx  <= lut_off;
                lut_pend_data <= WORD_W'(host_wdata);
            end else if (!wave_busy && lut_pend) begin
                lut_pend <= 1'b0;
            end
        end
    end

    rfc_wave_seq #(.WORD_W(WORD_W), .WORDS(WORDS), .NUM_PRESETS(NUM_PRESETS), .DIV(DIV)) u_wave (
        .clk(clk), .rst_n(rst_n), .go(wave_go), .go_idx(go_idx),
        .lut_idx(seq_lidx), .lut_word(lut[seq_lidx]), .busy(wave_busy),
        .sclk(synth_sclk), .sdo(synth_sdo), .le(synth_le)
    );

    // gain pair: change detection against applied codes
    assign gain_go  = !dac_busy && (gain_pend || wr_gain);
    assign gain_val = gain_pend ? gain_pend_val : host_wdata[2*CODE_W-1:0];
    assign chg_a    = gain_val[CODE_W-1:0] != gain_a;
    assign chg_b    = gain_val[2*CODE_W-1:CODE_W] != gain_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_a        <= '0;
            gain_b        <= '0;
            gain_pend     <= 1'b0;
            gain_pend_val <= '0;
        end else begin
            if (gain_go) begin
                gain_a <= gain_val[CODE_W-1:0];
                gain_b <= gain_val[2*CODE_W-1:CODE_W];
            end
            if (wr_gain && (dac_busy || gain_pend)) begin
                gain_pend     <= 1'b1;
                gain_pend_val <= host_wdata[2*CODE_W-1:0];
            end else if (!dac_busy && gain_pend) begin
                gain_pend <= 1'b0;
            end
        end
    end

    rfc_gain_seq #(.CODE_W(CODE_W), .DIV(DIV)) u_gain (
        .clk(clk), .rst_n(rst_n), .go(gain_go && (chg_a || chg_b)),
        .chg_a(chg_a), .chg_b(chg_b),
        .code_a(gain_val[CODE_W-1:0]), .code_b(gain_val[2*CODE_W-1:CODE_W]),
        .busy(dac_busy), .sclk(dac_sclk), .sdo(dac_sdo), .cs_n(dac_cs_n)
    );

    // antenna: applied only on a ramp trigger rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ant_req <= 1'b0;
            ramp_q  <= 1'b0;
            ant_sel <= 1'b0;
        end else begin
            ramp_q <= ramp_trig;
            if (wr_ant) ant_req <= host_wdata[0];
            if (ramp_trig && !ramp_q) ant_sel <= ant_req;
        end
    end

    // readback
    always_comb begin
        host_rdata = '0;
        if (lut_hit) begin
            host_rdata = HDATA_W'(lut[lut_off]);
        end else begin
            case (host_addr)
                ADDR_W'(ADR_WAVE): host_rdata = HDATA_W'({cur_idx, 1'b0});
                ADDR_W'(ADR_GAIN): host_rdata = HDATA_W'({gain_b, gain_a});
                ADDR_W'(ADR_ANT):  host_rdata = HDATA_W'({ant_sel, ant_req});
                ADDR_W'(ADR_STAT): host_rdata = HDATA_W'({dac_busy | gain_pend,
                                                          wave_busy | apply_pend | lut_pend});
                default:           host_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rfcfg_ctrl_chk.sv
`timescale 1ns/1ps
module rfcfg_ctrl_chk #(
    parameter int WORD_W = 32
) (
    input logic clk,
    input logic rst_n,
    input logic synth_sclk,
    input logic synth_sdo,
    input logic synth_le,
    input logic dac_sclk,
    input logic dac_cs_n,
    input logic ramp_trig,
    input logic ant_sel,
    input logic synth_busy_i
);
    logic        trig_q, ssclk_q, dsclk_q;
    int unsigned sbits, dbits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q  <= 1'b0;
            ssclk_q <= 1'b0;
            dsclk_q <= 1'b0;
            sbits   <= 0;
            dbits   <= 0;
        end else begin
            trig_q  <= ramp_trig;
            ssclk_q <= synth_sclk;
            dsclk_q <= dac_sclk;
            if (synth_le)                     sbits <= 0;
            else if (synth_sclk && !ssclk_q)  sbits <= sbits + 1;
            if (dac_cs_n)                     dbits <= 0;
            else if (dac_sclk && !dsclk_q)    dbits <= dbits + 1;
        end
    end

    assert_le_clock_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        synth_le |-> !synth_sclk);
    assert_word_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synth_le) |-> (sbits == WORD_W));
    assert_busy_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        synth_le |-> synth_busy_i);
    assert_frame_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs_n) |-> (dbits == 16));
    assert_cs_clock_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dac_cs_n |-> !dac_sclk);
    assert_ant_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ramp_trig && !trig_q) |=> $stable(ant_sel));
    assert_sdo_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (synth_sclk && ssclk_q) |-> $stable(synth_sdo));
endmodule

bind rfcfg_ctrl rfcfg_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .synth_sclk(synth_sclk), .synth_sdo(synth_sdo),
    .synth_le(synth_le), .dac_sclk(dac_sclk), .dac_cs_n(dac_cs_n),
    .ramp_trig(ramp_trig), .ant_sel(ant_sel), .synth_busy_i(wave_busy)
);

// File: tb/rfcfg_ctrl_test.sv
`timescale 1ns/1ps
module rfcfg_ctrl_test;
    logic        clk = 0, rst_n = 0, host_wr = 0, ramp_trig = 0;
    logic [7:0]  host_addr = 0;
    logic [31:0] host_wdata = 0, host_rdata;
    logic        synth_sclk, synth_sdo, synth_le, dac_sclk, dac_sdo, dac_cs_n, ant_sel;

    int checks = 0, fails = 0;
    bit finished = 0;

    rfcfg_ctrl uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ramp_trig(ramp_trig),
        .synth_sclk(synth_sclk), .synth_sdo(synth_sdo), .synth_le(synth_le),
        .dac_sclk(dac_sclk), .dac_sdo(dac_sdo), .dac_cs_n(dac_cs_n), .ant_sel(ant_sel)
    );

    always #5 clk = ~clk;

    // serial capture
    logic [31:0] ssh = 0;
    logic [15:0] dsh = 0;
    logic [31:0] words [0:63];
    logic [15:0] frames [0:63];
    int wn = 0, fn = 0, sbits = 0, dbits = 0, bad_wlen = 0, bad_flen = 0;

    always @(posedge synth_sclk) if (rst_n) begin ssh = {ssh[30:0], synth_sdo}; sbits++; end
    always @(posedge synth_le) if (rst_n) begin
        if (wn < 64) words[wn] = ssh;
        if (sbits != 32) bad_wlen++;
        wn++; sbits = 0;
    end
    always @(posedge dac_sclk) if (rst_n) begin dsh = {dsh[14:0], dac_sdo}; dbits++; end
    always @(posedge dac_cs_n) if (rst_n) begin
        if (fn < 64) frames[fn] = dsh;
        if (dbits != 16) bad_flen++;
        fn++; dbits = 0;
    end

    function automatic logic [31:0] lutval(int p, int w);
        logic [31:0] k;
        k = 32'(p * 4 + w + 1);
        return k * 32'h9E3779B9;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_stat(input logic [31:0] mask);
        logic [31:0] s;
        repeat (20000) begin
            hread(8'd3, s);
            if ((s & mask) == 0) break;
            @(negedge clk);
        end
    endtask

    int ga = 0, gb = 0;
    task automatic gain_step(input int a, input int b);
        int fbase, en;
        logic [15:0] ef [0:1];
        logic [31:0] r;
        fbase = fn; en = 0;
        if (a != ga) begin ef[en] = {8'h00, 8'(a)}; en++; end
        if (b != gb) begin ef[en] = {8'h80, 8'(b)}; en++; end
        ga = a; gb = b;
        hwrite(8'd1, {16'h0, 8'(b), 8'(a)});
        repeat (3) @(negedge clk);
        wait_stat(32'h2);
        check("R6 frame count", 32'(fn - fbase), 32'(en));
        for (int i = 0; i < en; i++) check("R5 frame value", {16'h0, frames[fbase + i]}, {16'h0, ef[i]});
        hread(8'd1, r);
        check("R5 gain readback", r, {16'h0, 8'(gb), 8'(ga)});
    endtask

    initial begin
        logic [31:0] r;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 synth_sclk", {31'h0, synth_sclk}, 0);
        check("R1 synth_le", {31'h0, synth_le}, 0);
        check("R1 dac_cs_n", {31'h0, dac_cs_n}, 1);
        check("R1 ant_sel", {31'h0, ant_sel}, 0);
        hread(8'd3, r); check("R1 status", r, 0);
        hread(8'd1, r); check("R1 gain", r, 0);

        // R3 table fill and readback
        for (int p = 0; p < 4; p++)
            for (int w = 0; w < 4; w++) hwrite(8'(64 + p * 4 + w), lutval(p, w));
        for (int e = 0; e < 16; e++) begin
            hread(8'(64 + e), r);
            check("R3 table readback", r, lutval(e / 4, e % 4));
        end

        // R2 / R4 every preset
        for (int p = 3; p >= 0; p--) begin
            base = wn;
            hwrite(8'd0, 32'((p << 1) | 1));
            hread(8'd3, r); check("R4 busy after command", r & 1, 1);
            wait_stat(32'h1);
            check("R4 all words sent when idle", 32'(wn - base), 4);
            for (int w = 0; w < 4; w++) check("R2 preset word", words[base + w], lutval(p, w));
            hread(8'd0, r); check("R2 preset index readback", r, 32'(p << 1));
        end

        // R2 bit 0 clear sends nothing
        base = wn;
        hwrite(8'd0, 32'(2 << 1));
        repeat (40) @(negedge clk);
        check("R2 no send without start bit", 32'(wn - base), 0);

        // R8 queued table write and command
        base = wn;
        hwrite(8'd0, 32'((1 << 1) | 1));
        hwrite(8'd72, 32'hDEADBEEF);
        hread(8'd72, r); check("R8 held table write not visible", r, lutval(2, 0));
        hwrite(8'd0, 32'((2 << 1) | 1));
        hread(8'd3, r); check("R8 busy while held", r & 1, 1);
        wait_stat(32'h1);
        check("R8 chained word count", 32'(wn - base), 8);
        for (int w = 0; w < 4; w++) check("R8 first preset", words[base + w], lutval(1, w));
        check("R8 updated word", words[base + 4], 32'hDEADBEEF);
        for (int w = 1; w < 4; w++) check("R8 second preset", words[base + 4 + w], lutval(2, w));
        hread(8'd72, r); check("R8 held write committed", r, 32'hDEADBEEF);
        check("R2 bits per word", 32'(bad_wlen), 0);

        // R5 / R6 gain sweep
        for (int i = 0; i < 10; i++) begin
            int a, b;
            a = (i % 4 == 1) ? ga : ((i * 53 + 7) & 255);
            b = (i % 3 == 0) ? gb : ((i * 29 + 100) & 255);
            gain_step(a, b);
        end
        gain_step(ga, gb);
        gain_step(ga, (gb + 1) & 255);

        // R9 held gain writes, last wins
        gain_step(8'h00, 8'h00);
        base = fn;
        hwrite(8'd1, 32'h1122);
        hwrite(8'd1, 32'h3344);
        hwrite(8'd1, 32'h5522);
        hread(8'd1, r); check("R9 readback before hold applied", r, 32'h1122);
        hread(8'd3, r); check("R9 dac busy flag", r & 2, 2);
        wait_stat(32'h2);
        check("R9 frame count", 32'(fn - base), 3);
        check("R9 frame A", {16'h0, frames[base]}, 32'h0022);
        check("R9 frame B", {16'h0, frames[base + 1]}, 32'h8011);
        check("R9 held frame", {16'h0, frames[base + 2]}, 32'h8055);
        hread(8'd1, r); check("R9 final gains", r, 32'h5522);
        check("R5 bits per frame", 32'(bad_flen), 0);

        // R7 antenna
        hwrite(8'd2, 32'h1);
        repeat (5) @(negedge clk);
        check("R7 hold before trigger", {31'h0, ant_sel}, 0);
        ramp_trig = 1;
        repeat (2) @(negedge clk);
        check("R7 update on rising trigger", {31'h0, ant_sel}, 1);
        hwrite(8'd2, 32'h0);
        repeat (3) @(negedge clk);
        check("R7 no update while trigger high", {31'h0, ant_sel}, 1);
        ramp_trig = 0;
        repeat (2) @(negedge clk);
        check("R7 no update on falling trigger", {31'h0, ant_sel}, 1);
        hread(8'd2, r); check("R7 readback", r, 32'h2);
        ramp_trig = 1;
        repeat (2) @(negedge clk);
        check("R7 second rising trigger", {31'h0, ant_sel}, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule